// File: doc/BRIEF.md
# Disk Controller Soft-Switch Decoder

This block is the memory-mapped control front end of a controller that serves two floppy drives. The CPU never writes a register in the usual sense. Any access that lands in a 32-byte address window has a side effect, and the low four address bits choose it. The side effects are: energising or releasing a stepper coil phase, starting or stopping the motor of the selected drive, choosing which drive is selected, loading the shared data latch, setting the read or write mode of the selected drive, and pulsing the byte strobe. The byte strobe moves one byte between the CPU and an external track buffer and then advances that drive's position within the current track.

The block keeps an online (motor) flag, a mode flag and a write-protect flag for each drive, plus one shared latch, a phase vector for the head stepper, and a byte position for each drive. The write-protect flag is a registered copy of the `wp_sense` input. `media_present` tells the block whether a drive holds a disk. The track buffer has a synchronous read port: it returns the byte at `tb_addr` one clock after the address is presented, and it stores `tb_wdata` on a clock edge where `tb_we` is high. The upper bit of `tb_addr` is the drive number, and the lower bits are that drive's byte position.

A byte transfer is handled by a three-state machine. `ST_IDLE` moves to `ST_ACCESS` on a strobe access (transition GO). `ST_ACCESS` always moves to `ST_COMPLETE` (transition ISSUE). `ST_COMPLETE` always returns to `ST_IDLE` (transition RETIRE). Accesses are only accepted while the machine is in `ST_IDLE`.

Top module: `disk_switch_decoder`

## Requirements
- R1: An access counts only when `cpu_strobe` is high and `cpu_addr` lies between 0xC0E0 and 0xC0FF inclusive. Both 16-byte halves of that window decode identically from `cpu_addr[3:0]`. An access outside the window changes no output and no state.
- R2: Offsets 0x0 to 0x7 drive the phase vector. An odd offset sets `phase` to the one-hot value `1 << cpu_addr[2:1]`, so 0x1, 0x3, 0x5 and 0x7 give 1, 2, 4 and 8. An even offset sets `phase` to 0. The new value is visible after the clock edge that samples the access.
- R3: Offset 0x9 sets the online flag of the selected drive, and offset 0x8 clears it. The other drive's flag does not change. `motor_on[i]` shows the flag of drive i.
- R4: Offset 0xA selects drive 0 and offset 0xB selects drive 1. While idle, `tb_addr` equals {selected drive, that drive's position}.
- R5: Offset 0xE puts the selected drive into read mode, and offset 0xF puts it into write mode. Each drive keeps its own mode.
- R6: Offset 0xD copies `cpu_wdata` into the latch only when the selected drive is in write mode. In read mode the latch keeps its old value.
- R7: Offset 0xC in read mode, with a disk present, returns the track-buffer byte at the current position on `cpu_rdata`. It then advances that drive's position by one. `cpu_rdata` holds its value until the next strobe completes.
- R8: Offset 0xC in write mode with write protect set returns the byte at the current position and advances the position. It asserts no `tb_we`.
- R9: Offset 0xC in write mode with write protect clear asserts `tb_we` for one cycle, with `tb_wdata` equal to the latch. It returns 0 and advances the position. `tb_we` is never high while idle.
- R10: After reset, `phase`, `motor_on`, `cpu_rdata`, `tb_we` and `tb_addr` are 0. Drive 0 is selected, both drives are in read mode, and both write-protect flags are set.
- R11: A position of TRACK_LEN-1 advances to 0. Only the byte position wraps.
- R12: With `media_present` low for the selected drive, a strobe returns 0, writes nothing to the track buffer, and still advances the position.
- R13: While a transfer is in progress, meaning the machine is not in `ST_IDLE`, every access is dropped with no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_strobe | input | 1 | Access strobe, one cycle per access |
| cpu_wdata | input | DATA_W | CPU data for latch loads |
| cpu_rdata | output | DATA_W | Byte returned by the last strobe |
| wp_sense | input | 2 | Write-protect sense per drive |
| media_present | input | 2 | Disk present per drive |
| tb_addr | output | 1+POS_W | Track-buffer address {drive, position} |
| tb_we | output | 1 | Track-buffer write enable |
| tb_wdata | output | DATA_W | Track-buffer write data (latch) |
| tb_rdata | input | DATA_W | Track-buffer read data, one cycle after address |
| phase | output | 4 | Stepper phase vector |
| motor_on | output | 2 | Online flag per drive |

## Verification
Flag, select, latch and phase accesses take effect on the edge that samples the strobe. The bench therefore checks them at the falling edge right after that edge. A byte strobe finishes two edges later: the address is presented during `ST_ACCESS`, the buffer answers on the next edge, and `ST_COMPLETE` captures the byte and advances the position. The bench waits two extra falling edges before it compares `cpu_rdata`, the buffer contents and `tb_addr`. The busy-drop check places its second access exactly in the `ST_ACCESS` cycle.

// File: rtl/dsk_pkg.sv
package dsk_pkg;

    localparam int NUM_DRIVES = 2;
    localparam int PHASE_W    = 4;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_PHASE,
        OP_MOTOR_OFF,
        OP_MOTOR_ON,
        OP_SEL_A,
        OP_SEL_B,
        OP_STROBE,
        OP_LATCH,
        OP_MODE_RD,
        OP_MODE_WR
    } dsk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_COMPLETE
    } dsk_state_e;

    typedef enum logic [1:0] {
        XF_FETCH,
        XF_STORE,
        XF_BLANK
    } dsk_xfer_e;

    typedef struct packed {
        dsk_op_e    op;
        logic [1:0] phase_sel;
        logic       phase_on;
    } dsk_cmd_t;

endpackage

// File: rtl/dsk_switch_decode.sv
module dsk_switch_decode
    import dsk_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'hC0E0
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_strobe,
    input  logic              accept,
    output dsk_cmd_t          cmd
);
    localparam int                WIN_BITS = 5;
    localparam logic [ADDR_W-1:0] WIN_MASK = {ADDR_W{1'b1}} << WIN_BITS;

    logic       hit;
    logic [3:0] nib;

    assign nib = cpu_addr[3:0];
    assign hit = cpu_strobe && accept && ((cpu_addr & WIN_MASK) == (BASE & WIN_MASK));

    always_comb begin
        cmd.op        = OP_NONE;
        cmd.phase_sel = nib[2:1];
        cmd.phase_on  = nib[0];
        if (hit) begin
            if (!nib[3]) begin
                cmd.op = OP_PHASE;
            end else begin
                unique case (nib[2:0])
                    3'd0: cmd.op = OP_MOTOR_OFF;
                    3'd1: cmd.op = OP_MOTOR_ON;
                    3'd2: cmd.op = OP_SEL_A;
                    3'd3: cmd.op = OP_SEL_B;
                    3'd4: cmd.op = OP_STROBE;
                    3'd5: cmd.op = OP_LATCH;
                    3'd6: cmd.op = OP_MODE_RD;
                    3'd7: cmd.op = OP_MODE_WR;
                endcase
            end
        end
    end

endmodule

// File: rtl/dsk_drive_flags.sv
module dsk_drive_flags
    import dsk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  dsk_cmd_t              cmd,
    input  logic [DATA_W-1:0]     cpu_wdata,
    input  logic [NUM_DRIVES-1:0] wp_sense,
    output logic                  sel,
    output logic [NUM_DRIVES-1:0] online,
    output logic [NUM_DRIVES-1:0] mode_wr,
    output logic [NUM_DRIVES-1:0] wp,
    output logic [DATA_W-1:0]     latch,
    output logic [PHASE_W-1:0]    phase
);

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drive
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                online[g]  <= 1'b0;
                mode_wr[g] <= 1'b0;
                wp[g]      <= 1'b1;
            end else begin
                wp[g] <= wp_sense[g];
                if (sel == 1'(g)) begin
                    case (cmd.op)
                        OP_MOTOR_OFF: online[g]  <= 1'b0;
                        OP_MOTOR_ON:  online[g]  <= 1'b1;
                        OP_MODE_RD:   mode_wr[g] <= 1'b0;
                        OP_MODE_WR:   mode_wr[g] <= 1'b1;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel   <= 1'b0;
            latch <= '0;
            phase <= '0;
        end else begin
            case (cmd.op)
                OP_SEL_A: sel <= 1'b0;
                OP_SEL_B: sel <= 1'b1;
                OP_LATCH: if (mode_wr[sel]) latch <= cpu_wdata;
                OP_PHASE: phase <= cmd.phase_on ? (PHASE_W'(1) << cmd.phase_sel) : '0;
                default: ;
            endcase
        end
    end

    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase)); // R2
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.op != OP_SEL_A && cmd.op != OP_SEL_B) |=> $stable(sel)); // R4
    AST_LATCH_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.op == OP_LATCH && !mode_wr[sel]) |=> $stable(latch)); // R6

endmodule

// File: rtl/dsk_stream_fsm.sv
module dsk_stream_fsm
    import dsk_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int TRACK_LEN = 6656,
    localparam int POS_W    = (TRACK_LEN > 1) ? $clog2(TRACK_LEN) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic                  sel,
    input  logic [NUM_DRIVES-1:0] mode_wr,
    input  logic [NUM_DRIVES-1:0] wp,
    input  logic [NUM_DRIVES-1:0] media,
    input  logic [DATA_W-1:0]     latch,
    input  logic [DATA_W-1:0]     tb_rdata,
    output logic                  idle,
    output logic [POS_W:0]        tb_addr,
    output logic                  tb_we,
    output logic [DATA_W-1:0]     tb_wdata,
    output logic [DATA_W-1:0]     cpu_rdata
);
    localparam logic [POS_W-1:0] LAST = POS_W'(TRACK_LEN - 1);

    dsk_state_e       state_q, state_d;
    dsk_xfer_e        kind_q, kind_d;
    logic             xfer_drv;
    logic [POS_W-1:0] pos_q [NUM_DRIVES];
    logic [POS_W-1:0] pos_cur;
    logic             act_drv;

    always_comb begin
        if (!media[sel])
            kind_d = XF_BLANK;
        else if (mode_wr[sel] && !wp[sel])
            kind_d = XF_STORE;
        else
            kind_d = XF_FETCH;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:     state_d = go ? ST_ACCESS : ST_IDLE;
            ST_ACCESS:   state_d = ST_COMPLETE;
            ST_COMPLETE: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_drv  <= 1'b0;
            kind_q    <= XF_FETCH;
            cpu_rdata <= '0;
            for (int i = 0; i < NUM_DRIVES; i++) pos_q[i] <= '0;
        end else begin
            if (state_q == ST_IDLE && go) begin
                xfer_drv <= sel;
                kind_q   <= kind_d;
            end
            if (state_q == ST_COMPLETE) begin
                cpu_rdata       <= (kind_q == XF_FETCH) ? tb_rdata : '0;
                pos_q[xfer_drv] <= (pos_q[xfer_drv] == LAST) ? '0 : pos_q[xfer_drv] + 1'b1;
            end
        end
    end

    always_comb begin
        idle     = (state_q == ST_IDLE);
        act_drv  = idle ? sel : xfer_drv;
        tb_addr  = {act_drv, pos_q[act_drv]};
        tb_we    = (state_q == ST_ACCESS) && (kind_q == XF_STORE);
        tb_wdata = latch;
        pos_cur  = pos_q[xfer_drv];
    end

    AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMPLETE && pos_cur != LAST) |=> pos_cur == POS_W'($past(pos_cur) + 1'b1)); // R7
    AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMPLETE && pos_cur == LAST) |=> pos_cur == '0); // R11
    AST_STORE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMPLETE && kind_q == XF_STORE) |=> cpu_rdata == '0); // R9
    AST_WE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        tb_we |-> $past(media[sel] && mode_wr[sel] && !wp[sel])); // R12
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !go) |=> $stable(cpu_rdata)); // R7

endmodule

// File: rtl/disk_switch_decoder.sv
module disk_switch_decoder
    import dsk_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE      = 16'hC0E0,
    parameter int                DATA_W    = 8,
    parameter int                TRACK_LEN = 6656,
    localparam int               POS_W     = (TRACK_LEN > 1) ? $clog2(TRACK_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_strobe,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [1:0]        wp_sense,
    input  logic [1:0]        media_present,
    output logic [POS_W:0]    tb_addr,
    output logic              tb_we,
    output logic [DATA_W-1:0] tb_wdata,
    input  logic [DATA_W-1:0] tb_rdata,
    output logic [3:0]        phase,
    output logic [1:0]        motor_on
);
    dsk_cmd_t                cmd;
    logic                    idle;
    logic                    sel;
    logic [NUM_DRIVES-1:0]   mode_wr;
    logic [NUM_DRIVES-1:0]   wp;
    logic [DATA_W-1:0]       latch;

    dsk_switch_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_decode (
        .cpu_addr   (cpu_addr),
        .cpu_strobe (cpu_strobe),
        .accept     (idle),
        .cmd        (cmd)
    );

    dsk_drive_flags #(.DATA_W(DATA_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .cpu_wdata (cpu_wdata),
        .wp_sense  (wp_sense),
        .sel       (sel),
        .online    (motor_on),
        .mode_wr   (mode_wr),
        .wp        (wp),
        .latch     (latch),
        .phase     (phase)
    );

    dsk_stream_fsm #(.DATA_W(DATA_W), .TRACK_LEN(TRACK_LEN)) u_stream (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (cmd.op == OP_STROBE),
        .sel       (sel),
        .mode_wr   (mode_wr),
        .wp        (wp),
        .media     (media_present),
        .latch     (latch),
        .tb_rdata  (tb_rdata),
        .idle      (idle),
        .tb_addr   (tb_addr),
        .tb_we     (tb_we),
        .tb_wdata  (tb_wdata),
        .cpu_rdata (cpu_rdata)
    );

    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && cpu_strobe) |=> ($stable(phase) && $stable(motor_on))); // R13
    AST_WE_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !tb_we); // R9

endmodule

// File: tb/test_disk_switch_decoder.sv
module test_disk_switch_decoder;
    localparam int          TL   = 37;
    localparam int          PW   = $clog2(TL);
    localparam int          AW   = PW + 1;
    localparam logic [15:0] BASE = 16'hC0E0;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [15:0]   cpu_addr;
    logic          cpu_strobe;
    logic [7:0]    cpu_wdata;
    logic [7:0]    cpu_rdata;
    logic [1:0]    wp_sense;
    logic [1:0]    media_present;
    logic [AW-1:0] tb_addr;
    logic          tb_we;
    logic [7:0]    tb_wdata;
    logic [7:0]    tb_rdata;
    logic [3:0]    phase;
    logic [1:0]    motor_on;

    logic [7:0] mem     [1 << AW];
    logic [7:0] exp_mem [1 << AW];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [PW-1:0] m_pos [2];
    logic [1:0]    m_on, m_wr;
    logic          m_sel;
    logic [7:0]    m_latch, m_rdata;
    logic [3:0]    m_phase;
    string         rtag;

    always #10 clk = ~clk;

    disk_switch_decoder #(.ADDR_W(16), .BASE(BASE), .DATA_W(8), .TRACK_LEN(TL)) i_disk_switch_decoder (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_strobe(cpu_strobe),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .wp_sense(wp_sense),
        .media_present(media_present), .tb_addr(tb_addr), .tb_we(tb_we),
        .tb_wdata(tb_wdata), .tb_rdata(tb_rdata), .phase(phase), .motor_on(motor_on)
    );

    always @(posedge clk) begin
        if (tb_we) mem[tb_addr] <= tb_wdata;
        tb_rdata <= mem[tb_addr];
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_phase(input logic [3:0] off);
        if (!off[0]) return 4'h0;
        return 4'h1 << off[2:1];
    endfunction

    task automatic check_all();
        check("R2 phase", phase, m_phase);
        check("R3 motor_on", motor_on, m_on);
        check("R4 R7 tb_addr", tb_addr, {m_sel, m_pos[m_sel]});
        check("R9 tb_we idle", tb_we, 0);
        check({rtag, " cpu_rdata"}, cpu_rdata, m_rdata);
    endtask

    task automatic pulse(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_strobe = 1'b1;
        @(negedge clk);
        cpu_strobe = 1'b0;
    endtask

    task automatic do_op(input logic [3:0] off, input logic [7:0] d, input logic hi);
        logic [AW-1:0] idx;
        pulse(BASE | {11'b0, hi, off}, d);
        idx = {m_sel, m_pos[m_sel]};
        if (!off[3]) m_phase = exp_phase(off);
        else begin
            case (off[2:0])
                3'd0: m_on[m_sel] = 1'b0;
                3'd1: m_on[m_sel] = 1'b1;
                3'd2: m_sel = 1'b0;
                3'd3: m_sel = 1'b1;
                3'd5: if (m_wr[m_sel]) m_latch = d;
                3'd6: m_wr[m_sel] = 1'b0;
                3'd7: m_wr[m_sel] = 1'b1;
                default: begin
                    if (!media_present[m_sel]) begin
                        m_rdata = 0; rtag = "R12";
                    end else if (m_wr[m_sel] && !wp_sense[m_sel]) begin
                        exp_mem[idx] = m_latch; m_rdata = 0; rtag = "R9";
                    end else begin
                        m_rdata = exp_mem[idx]; rtag = m_wr[m_sel] ? "R8" : "R7";
                    end
                    m_pos[m_sel] = (m_pos[m_sel] == PW'(TL - 1)) ? '0 : m_pos[m_sel] + 1'b1;
                    @(negedge clk);
                    @(negedge clk);
                    check({rtag, " R6 buffer"}, mem[idx], exp_mem[idx]);
                end
            endcase
        end
        check_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [PW-1:0] start;
        seed = $urandom(32'h1A2B3C);
        for (int i = 0; i < (1 << AW); i++) begin
            mem[i] = 8'($urandom);
            exp_mem[i] = mem[i];
        end
        rst_n = 1'b0; cpu_addr = '0; cpu_strobe = 1'b0; cpu_wdata = '0;
        wp_sense = 2'b11; media_present = 2'b11;
        m_pos[0] = '0; m_pos[1] = '0; m_on = '0; m_wr = '0; m_sel = 1'b0;
        m_latch = '0; m_rdata = '0; m_phase = '0; rtag = "R10";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all(); // R10 reset state

        // R2 phases
        for (int k = 0; k < 8; k++) do_op(4'(k), 8'h00, k[0]);
        do_op(4'h7, 0, 0); do_op(4'h2, 0, 1);
        // R3 / R4 per-drive online
        do_op(4'h9, 0, 0); do_op(4'hB, 0, 0); do_op(4'h9, 0, 1); do_op(4'h8, 0, 0);
        do_op(4'hA, 0, 1);
        // R5 / R6 latch ignored in read mode, then stores
        do_op(4'hE, 0, 0); do_op(4'hD, 8'h55, 0); do_op(4'hF, 0, 0);
        do_op(4'hC, 0, 0);                               // R8 protected
        wp_sense = 2'b00;
        do_op(4'hD, 8'hA5, 0); do_op(4'hC, 0, 0);        // R9 store
        do_op(4'hE, 0, 1); do_op(4'hD, 8'h3C, 0);        // R6 ignored
        do_op(4'hF, 0, 0); do_op(4'hC, 0, 0);            // R6 latch still A5
        do_op(4'hE, 0, 0); do_op(4'hC, 0, 0);            // R7 read
        // R12 no medium
        media_present = 2'b10;
        do_op(4'hF, 0, 0); do_op(4'hC, 0, 0); do_op(4'hE, 0, 0); do_op(4'hC, 0, 0);
        media_present = 2'b11;
        // R1 outside window
        pulse(16'hC0D9, 0); check_all();
        pulse(16'hC101, 0); check_all();
        pulse(16'hC0DC, 0); @(negedge clk); @(negedge clk); check_all();
        pulse(16'h40EB, 0); check_all();
        // R13 access dropped during transfer
        @(negedge clk);
        cpu_addr = BASE | 16'hC; cpu_strobe = 1'b1;
        @(negedge clk);
        cpu_addr = BASE | 16'h8;
        @(negedge clk);
        cpu_strobe = 1'b0;
        @(negedge clk);
        m_rdata = exp_mem[{m_sel, m_pos[m_sel]}];
        m_pos[m_sel] = (m_pos[m_sel] == PW'(TL - 1)) ? '0 : m_pos[m_sel] + 1'b1;
        rtag = "R13";
        check_all();
        // R11 wrap on drive 1
        do_op(4'hB, 0, 0); do_op(4'hE, 0, 0);
        start = m_pos[1];
        for (int k = 0; k < TL; k++) do_op(4'hC, 0, k[0]);
        check("R11 wrap position", tb_addr, {1'b1, start});
        // random mix
        for (int k = 0; k < 600; k++) begin
            if ($urandom % 8 == 0) wp_sense = 2'($urandom);
            if ($urandom % 16 == 0) media_present = 2'($urandom | 1);
            if ($urandom % 10 == 0) begin
                pulse(16'($urandom) | 16'h0100, 8'($urandom));
                @(negedge clk); @(negedge clk);
                check_all(); // R1
            end else begin
                do_op(4'($urandom), 8'($urandom), 1'($urandom));
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule